// File: doc/BRIEF.md
# Serial Link Frame Transmitter

This block is the sending half of a link layer that moves one frame at a time over a serial link in which every transmitted Dword is either a control primitive or a data word. While idle it sends SYNC words so the receiver stays bit-locked. When the transport layer offers a payload, the block asks for the link by repeating X_RDY until the far end answers with R_RDY. It then sends the frame as SOF, the payload Dwords, one CRC Dword and EOF. After that it sends WTRM until the far end reports a final status. The status is returned to the transport layer as a one-cycle pulse.

Payload words arrive on a valid/ready interface with a last-word marker. Decoded primitives from the receive path arrive as a 4-bit code with a qualifier. Words leave on a registered output that carries a primitive flag, a primitive code and a data word, ready for the encoder. Flow control works both ways. If the transport layer runs dry in the middle of a frame, HOLD is sent. If the far end sends HOLD, HOLDA is returned and no payload is taken. An ALIGN primitive is slipped into the stream on a fixed schedule, whatever the phase. The sequence resumes after it without losing its place.

Top module: `txl_frame_tx`

## Requirements
- R1: Primitive codes on `o_prim` and `rx_code` are SYNC=0, ALIGN=1, X_RDY=2, R_RDY=3, R_IP=4, SOF=5, EOF=6, WTRM=7, HOLD=8, HOLDA=9, R_OK=10, R_ERR=11. While in reset and while idle with `tx_valid` low, the output is SYNC with `o_prim_en`=1.
- R2: When `tx_valid` is high in idle, the next output word is X_RDY, and X_RDY repeats until R_RDY is received.
- R3: The edge at which R_RDY is received emits SOF. No payload word is accepted in that cycle.
- R4: In the payload phase, `tx_ready` is high exactly when a word is accepted. The accepted `tx_data` appears on `o_data` with `o_prim_en`=0 in the next cycle. Words keep their order, and `tx_last` ends the payload.
- R5: In the payload phase, an incoming HOLD makes the block emit HOLDA and accept nothing. Otherwise, `tx_valid` low makes it emit HOLD. Payload resumes when both clear.
- R6: After the last payload word comes one data Dword holding the CRC, then EOF. The CRC uses polynomial 0x04C11DB7, an all-ones seed and no final inversion. It covers only the payload words, each fed most-significant bit first.
- R7: After EOF, WTRM repeats until R_OK, R_ERR or SYNC is received.
- R8: Receiving R_OK, R_ERR or SYNC while waiting emits SYNC and raises `done_valid` for one cycle in that same cycle. `done_status` is 0 for R_OK, 1 for R_ERR and 2 for SYNC (aborted). The block is then idle.
- R9: No more than ALIGN_INTERVAL-1 consecutive output words are non-ALIGN. ALIGN is emitted exactly when that count is reached. The cycle it takes neither advances the phase nor accepts a word nor reports status.
- R10: Primitives that are not expected in the current phase are ignored. Examples are R_RDY or R_OK while idle, and R_IP or R_RDY while waiting for status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Transport offers a payload word (also requests a frame when idle) |
| tx_data | input | 32 | Payload word |
| tx_last | input | 1 | Offered word is the final payload word |
| tx_ready | output | 1 | Offered word is taken at this edge |
| rx_vld | input | 1 | `rx_code` holds a decoded primitive |
| rx_code | input | 4 | Primitive code from the receive path |
| o_prim_en | output | 1 | Output word is a primitive (1) or data (0) |
| o_prim | output | 4 | Primitive code of the output word |
| o_data | output | 32 | Data word (payload or CRC); zero for primitives |
| done_valid | output | 1 | One-cycle status report |
| done_status | output | 2 | 0 success, 1 error, 2 aborted |

## Verification
The assertions check the following on every cycle:
- the ALIGN spacing limit;
- that an accepted word is the next data Dword;
- that SOF only follows X_RDY;
- that HOLDA only answers a received HOLD;
- that EOF only follows a data Dword;
- that WTRM is followed only by WTRM, SYNC or ALIGN;
- that a status pulse coincides with a return to SYNC.

Other properties need whole frames and are shown only by the bench's scenarios and its cycle-by-cycle model. These are the value of the CRC Dword, the mapping of each far-end response to its status code, transport stalls versus far-end holds, ALIGN landing in every phase of a long frame, and unexpected primitives being ignored.

// File: rtl/txl_pkg.sv
package txl_pkg;

    localparam int DWORD_W = 32;
    localparam int CRC_W   = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0] CRC_SEED = {CRC_W{1'b1}};
    localparam int CODE_W  = 4;
    localparam int STAT_W  = 2;

    typedef enum logic [CODE_W-1:0] {
        P_SYNC  = 4'd0,
        P_ALIGN = 4'd1,
        P_XRDY  = 4'd2,
        P_RRDY  = 4'd3,
        P_RIP   = 4'd4,
        P_SOF   = 4'd5,
        P_EOF   = 4'd6,
        P_WTRM  = 4'd7,
        P_HOLD  = 4'd8,
        P_HOLDA = 4'd9,
        P_ROK   = 4'd10,
        P_RERR  = 4'd11
    } prim_e;

    typedef enum logic [STAT_W-1:0] {
        ST_OK    = 2'd0,
        ST_ERR   = 2'd1,
        ST_ABORT = 2'd2
    } stat_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARB,
        S_PAY,
        S_CRC,
        S_EOF,
        S_WAIT
    } phase_e;

    typedef struct packed {
        logic rrdy;
        logic hold;
        logic ok;
        logic err;
        logic sync;
    } rxev_t;

    typedef struct packed {
        phase_e               ph;
        logic                 en;
        prim_e                prim;
        logic [DWORD_W-1:0]   data;
        logic                 done;
        stat_e                stat;
    } txr_t;

    function automatic logic [CRC_W-1:0] crc_step(
        input logic [CRC_W-1:0]   c,
        input logic [DWORD_W-1:0] w
    );
        logic [CRC_W-1:0] r;
        logic             fb;
        r = c;
        for (int i = DWORD_W - 1; i >= 0; i--) begin
            fb = r[CRC_W-1] ^ w[i];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/txl_rx_classify.sv
module txl_rx_classify
    import txl_pkg::*;
(
    input  logic              vld,
    input  logic [CODE_W-1:0] code,
    output rxev_t             ev
);
    always_comb begin
        ev      = '0;
        ev.rrdy = vld && (code == P_RRDY);
        ev.hold = vld && (code == P_HOLD);
        ev.ok   = vld && (code == P_ROK);
        ev.err  = vld && (code == P_RERR);
        ev.sync = vld && (code == P_SYNC);
    end
endmodule

// File: rtl/txl_align_pacer.sv
module txl_align_pacer #(
    parameter int INTERVAL = 256
) (
    input  logic clk,
    input  logic rst_n,
    output logic due
);
    localparam int CW = $clog2(INTERVAL);
    localparam logic [CW-1:0] LIMIT = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    // count of non-ALIGN words currently shown; reset word counts as one
    always_comb begin
        due   = (cnt_q == LIMIT);
        cnt_d = due ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= CW'(1);
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/txl_crc_unit.sv
module txl_crc_unit
    import txl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               init,
    input  logic               upd,
    input  logic [DWORD_W-1:0] word,
    output logic [CRC_W-1:0]   crc
);
    logic [CRC_W-1:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (init)     crc_d = CRC_SEED;
        else if (upd) crc_d = crc_step(crc_q, word);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= CRC_SEED;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;
endmodule

// File: rtl/txl_frame_tx.sv
module txl_frame_tx
    import txl_pkg::*;
#(
    parameter int ALIGN_INTERVAL = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_valid,
    input  logic [DWORD_W-1:0] tx_data,
    input  logic               tx_last,
    output logic               tx_ready,
    input  logic               rx_vld,
    input  logic [CODE_W-1:0]  rx_code,
    output logic               o_prim_en,
    output logic [CODE_W-1:0]  o_prim,
    output logic [DWORD_W-1:0] o_data,
    output logic               done_valid,
    output logic [STAT_W-1:0]  done_status
);
    txr_t             r_d, r_q;
    rxev_t            ev;
    logic             align_due;
    logic             crc_init, crc_upd, take;
    logic [CRC_W-1:0] crc_cur;

    txl_rx_classify u_cls (
        .vld  (rx_vld),
        .code (rx_code),
        .ev   (ev)
    );

    txl_align_pacer #(.INTERVAL(ALIGN_INTERVAL)) u_pace (
        .clk   (clk),
        .rst_n (rst_n),
        .due   (align_due)
    );

    txl_crc_unit u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (crc_init),
        .upd   (crc_upd),
        .word  (tx_data),
        .crc   (crc_cur)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.data = '0;
        r_d.en   = 1'b1;
        crc_init = 1'b0;
        crc_upd  = 1'b0;
        take     = 1'b0;
        if (align_due) begin
            r_d.prim = P_ALIGN;
        end else begin
            unique case (r_q.ph)
                S_IDLE: begin
                    if (tx_valid) begin
                        r_d.prim = P_XRDY;
                        r_d.ph   = S_ARB;
                    end else begin
                        r_d.prim = P_SYNC;
                    end
                end
                S_ARB: begin
                    if (ev.rrdy) begin
                        r_d.prim = P_SOF;
                        r_d.ph   = S_PAY;
                        crc_init = 1'b1;
                    end else begin
                        r_d.prim = P_XRDY;
                    end
                end
                S_PAY: begin
                    if (ev.hold) begin
                        r_d.prim = P_HOLDA;
                    end else if (tx_valid) begin
                        r_d.en   = 1'b0;
                        r_d.prim = P_SYNC;
                        r_d.data = tx_data;
                        take     = 1'b1;
                        crc_upd  = 1'b1;
                        if (tx_last) r_d.ph = S_CRC;
                    end else begin
                        r_d.prim = P_HOLD;
                    end
                end
                S_CRC: begin
                    r_d.en   = 1'b0;
                    r_d.prim = P_SYNC;
                    r_d.data = crc_cur;
                    r_d.ph   = S_EOF;
                end
                S_EOF: begin
                    r_d.prim = P_EOF;
                    r_d.ph   = S_WAIT;
                end
                S_WAIT: begin
                    r_d.prim = P_SYNC;
                    if (ev.ok) begin
                        r_d.done = 1'b1;
                        r_d.stat = ST_OK;
                        r_d.ph   = S_IDLE;
                    end else if (ev.err) begin
                        r_d.done = 1'b1;
                        r_d.stat = ST_ERR;
                        r_d.ph   = S_IDLE;
                    end else if (ev.sync) begin
                        r_d.done = 1'b1;
                        r_d.stat = ST_ABORT;
                        r_d.ph   = S_IDLE;
                    end else begin
                        r_d.prim = P_WTRM;
                    end
                end
                default: begin
                    r_d.prim = P_SYNC;
                    r_d.ph   = S_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.ph   <= S_IDLE;
            r_q.en   <= 1'b1;
            r_q.prim <= P_SYNC;
            r_q.data <= '0;
            r_q.done <= 1'b0;
            r_q.stat <= ST_OK;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_ready    = take;
    assign o_prim_en   = r_q.en;
    assign o_prim      = r_q.prim;
    assign o_data      = r_q.data;
    assign done_valid  = r_q.done;
    assign done_status = r_q.stat;
endmodule

// File: rtl/txl_frame_tx_chk.sv
module txl_frame_tx_chk
    import txl_pkg::*;
#(
    parameter int ALIGN_INTERVAL = 256
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tx_valid,
    input logic [DWORD_W-1:0] tx_data,
    input logic               tx_ready,
    input logic               rx_vld,
    input logic [CODE_W-1:0]  rx_code,
    input logic               o_prim_en,
    input logic [CODE_W-1:0]  o_prim,
    input logic [DWORD_W-1:0] o_data,
    input logic               done_valid,
    input logic [STAT_W-1:0]  done_status
);
    localparam int RW = $clog2(ALIGN_INTERVAL) + 2;

    logic          is_align;
    logic [RW-1:0] run_q, run_now;

    assign is_align = o_prim_en && (o_prim == P_ALIGN);
    assign run_now  = is_align ? '0 : run_q + RW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_now;
    end

    assert_align_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        run_now <= RW'(ALIGN_INTERVAL - 1));

    assert_take_is_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> tx_valid);

    assert_taken_word_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |=> (!o_prim_en && o_data == $past(tx_data)));

    assert_sof_after_xrdy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (o_prim_en && o_prim == P_SOF) |->
            $past(o_prim_en && (o_prim == P_XRDY || o_prim == P_ALIGN)));

    assert_holda_answers_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (o_prim_en && o_prim == P_HOLDA) |-> $past(rx_vld && rx_code == P_HOLD));

    assert_eof_after_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (o_prim_en && o_prim == P_EOF) |-> $past(!o_prim_en || o_prim == P_ALIGN));

    assert_wtrm_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (o_prim_en && o_prim == P_WTRM) |=>
            (o_prim_en && (o_prim == P_WTRM || o_prim == P_SYNC || o_prim == P_ALIGN)));

    assert_done_with_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (o_prim_en && o_prim == P_SYNC && done_status != 2'd3));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);
endmodule

bind txl_frame_tx txl_frame_tx_chk #(.ALIGN_INTERVAL(ALIGN_INTERVAL)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .tx_ready    (tx_ready),
    .rx_vld      (rx_vld),
    .rx_code     (rx_code),
    .o_prim_en   (o_prim_en),
    .o_prim      (o_prim),
    .o_data      (o_data),
    .done_valid  (done_valid),
    .done_status (done_status)
);

// File: tb/sim_txl_frame_tx.sv
`timescale 1ns/1ps
module sim_txl_frame_tx;
    import txl_pkg::*;

    localparam int AI = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_valid = 1'b0;
    logic [31:0] tx_data = '0;
    logic        tx_last = 1'b0;
    logic        tx_ready;
    logic        rx_vld = 1'b0;
    logic [3:0]  rx_code = 4'd0;
    logic        o_prim_en;
    logic [3:0]  o_prim;
    logic [31:0] o_data;
    logic        done_valid;
    logic [1:0]  done_status;

    int checks = 0;
    int errors = 0;
    int base   = 0;

    txl_frame_tx #(.ALIGN_INTERVAL(AI)) u0 (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .rx_vld(rx_vld), .rx_code(rx_code),
        .o_prim_en(o_prim_en), .o_prim(o_prim), .o_data(o_data),
        .done_valid(done_valid), .done_status(done_status)
    );

    initial forever #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] bcrc(input logic [31:0] c, input logic [31:0] w);
        logic [31:0] r = c;
        for (int i = 31; i >= 0; i--) begin
            bit top = r[31] ^ w[i];
            r = r << 1;
            if (top) r = r ^ 32'h04C1_1DB7;
        end
        return r;
    endfunction

    function automatic logic [31:0] word_of(input int i);
        return 32'h1357_0000 ^ (32'(i) * 32'h0001_0F1F) ^ (32'(base) << 20);
    endfunction

    // ---------------- behavioural reference, compared every cycle ----------------
    int          m_ph;   // 0 idle 1 arbitrate 2 payload 3 crc 4 eof 5 wait
    int          m_run;
    logic [31:0] m_crc;
    bit          e_en;
    int          e_prim;
    logic [31:0] e_data;
    bit          e_done;
    int          e_stat;
    string       e_req;

    always begin
        @(negedge clk);
        #1;
        if (!rst_n) begin
            m_ph = 0; m_run = 1; m_crc = 32'hFFFF_FFFF;
            e_en = 1; e_prim = 0; e_data = 0; e_done = 0; e_stat = 0; e_req = "R1";
        end else begin
            bit align_now, rxh, exp_rdy;
            chk(o_prim_en == e_en, e_req, "word kind", o_prim_en, e_en);
            if (e_en) chk(o_prim == 4'(e_prim), e_req, "primitive", o_prim, e_prim);
            else      chk(o_data == e_data, e_req, "data word", o_data, e_data);
            chk(done_valid == e_done, "R8", "done pulse", done_valid, e_done);
            if (e_done) chk(done_status == 2'(e_stat), "R8", "status", done_status, e_stat);
            align_now = (m_run == AI - 1);
            rxh = rx_vld && rx_code == 4'd8;
            exp_rdy = !align_now && m_ph == 2 && !rxh && tx_valid;
            chk(tx_ready == exp_rdy, "R4", "tx_ready", tx_ready, exp_rdy);
            e_done = 0; e_en = 1; e_data = 0;
            if (align_now) begin
                e_prim = 1; m_run = 0; e_req = "R9";
            end else begin
                m_run++;
                case (m_ph)
                    0: if (tx_valid) begin e_prim = 2; m_ph = 1; e_req = "R2"; end
                       else begin e_prim = 0; e_req = "R10"; end
                    1: if (rx_vld && rx_code == 4'd3) begin
                           e_prim = 5; m_ph = 2; m_crc = 32'hFFFF_FFFF; e_req = "R3";
                       end else begin e_prim = 2; e_req = "R2"; end
                    2: if (rxh) begin e_prim = 9; e_req = "R5"; end
                       else if (tx_valid) begin
                           e_en = 0; e_data = tx_data; m_crc = bcrc(m_crc, tx_data);
                           e_req = "R4"; if (tx_last) m_ph = 3;
                       end else begin e_prim = 8; e_req = "R5"; end
                    3: begin e_en = 0; e_data = m_crc; m_ph = 4; e_req = "R6"; end
                    4: begin e_prim = 6; m_ph = 5; e_req = "R6"; end
                    default: begin
                        e_prim = 0; e_req = "R8";
                        if (rx_vld && rx_code == 4'd10)     begin e_done = 1; e_stat = 0; m_ph = 0; end
                        else if (rx_vld && rx_code == 4'd11) begin e_done = 1; e_stat = 1; m_ph = 0; end
                        else if (rx_vld && rx_code == 4'd0)  begin e_done = 1; e_stat = 2; m_ph = 0; end
                        else begin e_prim = 7; e_req = "R7"; end
                    end
                endcase
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle_cycles(input int n, input int code);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tx_valid = 0; rx_vld = 1; rx_code = 4'(code);
            #1;
            chk(o_prim_en && (o_prim == 4'd0 || o_prim == 4'd1), "R10",
                "idle output", o_prim, 0);
        end
    endtask

    task automatic run_frame(input int n, input int stall_at, input int stall_len,
                             input int hold_at, input int hold_len, input int resp,
                             input int rrdy_wait, input int wtrm_wait);
        int idx = 0, xr = 0, wt = 0, sl = stall_len, hl = hold_len, guard = 0, got = -1;
        bit fire = 0, fin = 0, in_frame = 0, saw_sof = 0;
        bit saw_hold = 0, saw_holda = 0, saw_align = 0;
        logic [31:0] crc = 32'hFFFF_FFFF, last_dw = 0, seen_crc = 0;
        int exp_stat = (resp == 10) ? 0 : (resp == 11) ? 1 : 2;
        base++;
        while (!fin && guard < 3000) begin
            @(negedge clk);
            guard++;
            if (fire) begin crc = bcrc(crc, word_of(idx)); idx++; end
            if (done_valid) begin fin = 1; got = int'(done_status); end
            if (o_prim_en) begin
                if (o_prim == 4'd8) saw_hold = 1;
                if (o_prim == 4'd9) saw_holda = 1;
                if (o_prim == 4'd1) saw_align = 1;
                if (o_prim == 4'd5) saw_sof = 1;
                if (o_prim == 4'd6) seen_crc = last_dw;
            end else last_dw = o_data;
            // transport side
            if (!fin && idx < n) begin
                if (idx == stall_at && sl > 0) begin tx_valid = 0; sl--; end
                else begin tx_valid = 1; tx_data = word_of(idx); tx_last = (idx == n - 1); end
            end else begin
                tx_valid = 0; tx_last = 0;
            end
            // far end
            rx_vld = 1;
            if (fin) rx_code = 4'd0;
            else if (o_prim_en && o_prim == 4'd2) begin
                in_frame = 1; xr++;
                rx_code = (xr > rrdy_wait) ? 4'd3 : 4'd0;
            end else if (o_prim_en && o_prim == 4'd7) begin
                wt++;
                if (wt > wtrm_wait) rx_code = 4'(resp);
                else if (wt == 1)   rx_code = 4'd3;   // stray R_RDY, ignored (R10)
                else                rx_code = 4'd4;
            end else if (in_frame) begin
                if (saw_sof && idx == hold_at && hl > 0) begin rx_code = 4'd8; hl--; end
                else rx_code = 4'd4;
            end else rx_code = 4'd0;
            #1;
            fire = tx_valid && tx_ready;
        end
        chk(fin, "R8", "frame finished", fin, 1);
        chk(got == exp_stat, "R8", "reported status", got, exp_stat);
        chk(idx == n, "R4", "payload words taken", idx, n);
        chk(seen_crc == crc, "R6", "CRC Dword", seen_crc, crc);
        if (stall_len > 0) chk(saw_hold, "R5", "HOLD on stall", saw_hold, 1);
        if (hold_len > 0)  chk(saw_holda, "R5", "HOLDA on far-end hold", saw_holda, 1);
        if (n > AI)        chk(saw_align, "R9", "ALIGN within long frame", saw_align, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #1;
        chk(o_prim_en && o_prim == 4'd0, "R1", "reset output SYNC", o_prim, 0);
        chk(!done_valid && !tx_ready, "R1", "reset quiet", {done_valid, tx_ready}, 0);
        @(negedge clk);
        rst_n = 1;
        idle_cycles(6, 0);
        idle_cycles(4, 3);   // R_RDY while idle ignored (R10)
        idle_cycles(4, 10);  // R_OK while idle ignored (R10)
        run_frame(4, -1, 0, -1, 0, 10, 3, 2);
        idle_cycles(3, 0);
        run_frame(6, 2, 3, -1, 0, 11, 1, 3);
        run_frame(5, -1, 0, 3, 2, 0, 0, 1);
        idle_cycles(2, 0);
        run_frame(40, 17, 2, 30, 3, 10, 2, 2);
        run_frame(1, -1, 0, -1, 0, 10, 0, 0);
        run_frame(2, 1, 1, 0, 1, 11, 5, 4);
        idle_cycles(AI + 2, 4);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog: run still active, actual %0d cycles expected fewer", 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule